// File: doc/BRIEF.md
# Load/Store Data Alignment Selector

This block is the combinational lane steering placed between a 32-bit processor datapath and a 32-bit memory bus. For loads, it takes the word returned by memory, picks out the byte or halfword named by the low address bits, and moves it to the bottom of the result. It then fills the upper bits with zeros or with copies of the sign bit. For stores, it copies narrow store data into every lane of the write bus and produces the per-byte write enables that tell memory which lanes to commit.

Memory is little-endian. Address bits [1:0] name the byte lane and address bit [1] names the halfword lane. The access size is encoded as 2'b00 for byte, 2'b01 for halfword, and 2'b10 or 2'b11 for word. The outputs are driven for every access. The surrounding controller gates the byte enables with its own write strobe, and it discards the load value on stores.

Top module: `ls_align_sel`

## Requirements
- R1: With size 2'b00, load_val[7:0] equals byte lane addr_lo of rd_word (lane n is bits [8n+7:8n]).
- R2: With size 2'b01, load_val[15:0] equals rd_word[31:16] when addr_lo[1] is 1 and rd_word[15:0] otherwise; addr_lo[0] has no effect.
- R3: When sign_ext is 0, byte loads have load_val[31:8] zero and halfword loads have load_val[31:16] zero.
- R4: When sign_ext is 1, every bit above the selected data equals bit 7 (byte) or bit 15 (halfword) of the selected data.
- R5: With size 2'b10, load_val equals rd_word, whatever the values of addr_lo and sign_ext.
- R6: With size 2'b00, all four byte lanes of wr_word equal st_data[7:0], and byte_en is one-hot with bit addr_lo set.
- R7: With size 2'b01, both halfwords of wr_word equal st_data[15:0], and byte_en is 4'b1100 when addr_lo[1] is 1 and 4'b0011 otherwise.
- R8: With size 2'b10, wr_word equals st_data and byte_en is 4'b1111.
- R9: Size code 2'b11 behaves exactly as a word access (load, write data and enables).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_lo | input | 2 | Low two bits of the access address |
| size | input | 2 | Access size: 00 byte, 01 halfword, 10/11 word |
| sign_ext | input | 1 | 1 sign-extends narrow loads, 0 zero-extends |
| rd_word | input | 32 | Word returned by memory on a load |
| st_data | input | 32 | Register value to be stored |
| load_val | output | 32 | Aligned and extended load result |
| wr_word | output | 32 | Write bus with the store data replicated |
| byte_en | output | 4 | Per-lane write enables |

## Verification
Loads are tried at every address, with read words whose selected lane has its top bit set or clear, at both settings of sign_ext. This separates a wrong lane choice from a wrong extension. For each byte lane, the bench uses a word with four distinct lane values, so that a swapped lane shows up as a wrong value. Halfword and byte stores use store data whose upper bytes differ from the low ones, which reveals any lane filled from the wrong source. A sweep over all address and size pairs, including code 2'b11, checks the enable patterns and shows that the word path ignores the address.

// File: rtl/ls_align_sel.sv
module ls_align_sel (
  input  logic [1:0]  addr_lo,
  input  logic [1:0]  size,
  input  logic        sign_ext,
  input  logic [31:0] rd_word,
  input  logic [31:0] st_data,
  output logic [31:0] load_val,
  output logic [31:0] wr_word,
  output logic [3:0]  byte_en
);

  logic [7:0]  pick_b;
  logic [15:0] pick_h;
  logic        is_byte, is_half;

  assign is_byte = (size == 2'b00);
  assign is_half = (size == 2'b01);

  assign pick_b = rd_word[{addr_lo, 3'b000} +: 8];
  assign pick_h = addr_lo[1] ? rd_word[31:16] : rd_word[15:0];

  always_comb begin
    if (is_byte)
      load_val = {{24{sign_ext & pick_b[7]}}, pick_b};
    else if (is_half)
      load_val = {{16{sign_ext & pick_h[15]}}, pick_h};
    else
      load_val = rd_word;
  end

  always_comb begin
    if (is_byte) begin
      wr_word = {4{st_data[7:0]}};
      byte_en = 4'b0001 << addr_lo;
    end else if (is_half) begin
      wr_word = {2{st_data[15:0]}};
      byte_en = addr_lo[1] ? 4'b1100 : 4'b0011;
    end else begin
      wr_word = st_data;
      byte_en = 4'b1111;
    end
  end

  always_comb begin
    if (size == 2'b00) begin
      p_byte_en_onehot_r6: assert ($countones(byte_en) == 1 && byte_en[addr_lo]);
      p_byte_lanes_r6: assert (wr_word[31:24] == wr_word[7:0] && wr_word[23:16] == wr_word[7:0]
                               && wr_word[15:8] == wr_word[7:0]);
      p_byte_zero_r3: assert (sign_ext || load_val[31:8] == 24'h0);
      p_byte_sign_r4: assert (!sign_ext || load_val[31:8] == {24{load_val[7]}});
    end
    if (size == 2'b01) begin
      p_half_en_r7: assert (byte_en == 4'b0011 || byte_en == 4'b1100);
      p_half_lanes_r7: assert (wr_word[31:16] == wr_word[15:0]);
      p_half_zero_r3: assert (sign_ext || load_val[31:16] == 16'h0);
      p_half_sign_r4: assert (!sign_ext || load_val[31:16] == {16{load_val[15]}});
    end
    if (size[1]) begin
      p_word_en_r8: assert (byte_en == 4'b1111);
      p_word_pass_r5: assert (load_val == rd_word && wr_word == st_data);
    end
  end

endmodule

// File: tb/test_ls_align_sel.sv
module test_ls_align_sel;
  logic clk = 1'b0;
  logic [1:0]  addr_lo = 2'b00;
  logic [1:0]  size = 2'b00;
  logic        sign_ext = 1'b0;
  logic [31:0] rd_word = 32'h0;
  logic [31:0] st_data = 32'h0;
  logic [31:0] load_val, wr_word;
  logic [3:0]  byte_en;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ls_align_sel i_ls_align_sel (
    .addr_lo(addr_lo), .size(size), .sign_ext(sign_ext), .rd_word(rd_word),
    .st_data(st_data), .load_val(load_val), .wr_word(wr_word), .byte_en(byte_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (addr %0d size %0d sx %0b)",
               req, act, exp, addr_lo, size, sign_ext);
    end
  endtask

  task automatic apply(input logic [1:0] a, input logic [1:0] s, input logic sx,
                       input logic [31:0] rd, input logic [31:0] st);
    @(negedge clk);
    addr_lo = a; size = s; sign_ext = sx; rd_word = rd; st_data = st;
    #2;
  endtask

  task automatic t_reset;
    #2;
    chk("R1 reset load", load_val, 32'h0);
    chk("R6 reset wr", wr_word, 32'h0);
    chk("R6 reset be", {28'h0, byte_en}, 32'h1);
  endtask

  task automatic t_byte_load;
    for (int a = 0; a < 4; a++) begin
      apply(a[1:0], 2'b00, 1'b0, 32'h44332211, 32'h0);
      chk("R1 byte lane", load_val, 32'h11 * (a + 1));
      apply(a[1:0], 2'b00, 1'b0, 32'h80808080 | (32'h11 << (8 * a)), 32'h0);
      chk("R3 byte zero ext", load_val, 32'h91);
      apply(a[1:0], 2'b00, 1'b1, 32'h80808080 | (32'h11 << (8 * a)), 32'h0);
      chk("R4 byte sign ext", load_val, 32'hFFFFFF91);
      apply(a[1:0], 2'b00, 1'b1, 32'h7F7F7F7F & ~(32'h80 << (8 * a)), 32'h0);
      chk("R4 byte positive", load_val, 32'h7F);
    end
  endtask

  task automatic t_half_load;
    for (int a = 0; a < 4; a++) begin
      logic [31:0] exp_lo;
      exp_lo = (a >= 2) ? 32'hB3C4 : 32'h1A2B;
      apply(a[1:0], 2'b01, 1'b0, 32'hB3C41A2B, 32'h0);
      chk("R2 R3 half lane zero ext", load_val, exp_lo);
      apply(a[1:0], 2'b01, 1'b1, 32'hB3C41A2B, 32'h0);
      chk("R4 half sign ext", load_val, (a >= 2) ? 32'hFFFFB3C4 : 32'h00001A2B);
    end
  endtask

  task automatic t_word_load;
    for (int a = 0; a < 4; a++) begin
      apply(a[1:0], 2'b10, a[0], 32'hDEADBEEF, 32'h0);
      chk("R5 word load", load_val, 32'hDEADBEEF);
    end
  endtask

  task automatic t_byte_store;
    for (int a = 0; a < 4; a++) begin
      apply(a[1:0], 2'b00, 1'b0, 32'h0, 32'h123456A7);
      chk("R6 byte wr", wr_word, 32'hA7A7A7A7);
      chk("R6 byte en", {28'h0, byte_en}, 32'h1 << a);
    end
  endtask

  task automatic t_half_store;
    for (int a = 0; a < 4; a++) begin
      apply(a[1:0], 2'b01, 1'b1, 32'h0, 32'h9ABC5E6F);
      chk("R7 half wr", wr_word, 32'h5E6F5E6F);
      chk("R7 half en", {28'h0, byte_en}, (a >= 2) ? 32'hC : 32'h3);
    end
  endtask

  task automatic t_word_store;
    for (int a = 0; a < 4; a++) begin
      apply(a[1:0], 2'b10, 1'b0, 32'h0, 32'hCAFE0123);
      chk("R8 word wr", wr_word, 32'hCAFE0123);
      chk("R8 word en", {28'h0, byte_en}, 32'hF);
    end
  endtask

  task automatic t_size3;
    for (int a = 0; a < 4; a++) begin
      apply(a[1:0], 2'b11, 1'b1, 32'h8000_0081, 32'h0F0E0D0C);
      chk("R9 size3 load", load_val, 32'h80000081);
      chk("R9 size3 wr", wr_word, 32'h0F0E0D0C);
      chk("R9 size3 en", {28'h0, byte_en}, 32'hF);
    end
  endtask

  initial begin
    t_reset();
    t_byte_load();
    t_half_load();
    t_word_load();
    t_byte_store();
    t_half_store();
    t_word_store();
    t_size3();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule